// File: doc/BRIEF.md
# LPC Bus I/O Cycle Target

This block sits on the four-bit multiplexed LAD bus of a Low Pin Count host link and answers host I/O read and write cycles. It watches the active-low frame input for a START nibble, decodes the cycle type and a full 16-bit address, and collects one data byte for writes. When the address falls inside its decode window, it takes over the bus after the host's turnaround. It then drives long-wait SYNC nibbles, returns the read byte, and hands the bus back.

Behind the bus side there is a plain register port. The block presents an address, write data and a read or write request that stays high until the internal target raises ready. The returned byte is captured on the same edge. If ready never comes, the cycle ends with an error SYNC. An active-low power-down input parks the block and tristates the DMA request line, and a synchronous bus reset releases every bus output.

Top module: `lpc_io_target`

## Requirements
- R1: While `rst_n` is low, `lad_oe`, `reg_rd` and `reg_wr` are low and the DMA request line is driven high (`dma_req_oe`=1, `dma_req_n`=1).
- R2: A cycle begins when `frame_n` is sampled low with LAD=0000. Type nibble 0000 is an I/O read. The address comes as four nibbles, most significant first. Two released turnaround clocks follow, then the target drives SYNC, then the data low nibble, then the high nibble, then 1111 for one clock, and then releases LAD.
- R3: Type nibble 0010 is an I/O write. Data follows the address as two nibbles, least significant first. The block presents that address and byte on `reg_addr`/`reg_wdata` with `reg_wr`. After the final SYNC it drives 1111 for one clock and releases LAD.
- R4: The first SYNC nibble is driven in the clock right after the second turnaround clock. With ready already high, a read shows exactly three 0110 nibbles and a write exactly two before the 0000 nibble.
- R5: While the internal target holds `reg_ready` low, the request stays high and the target keeps driving 0110. It drives 0000 in the clock after the one in which ready is seen, or after the fixed wait count, whichever is later. Read data is the `reg_rdata` value present with ready.
- R6: If ready is not seen within 330 wait nibbles, the next nibble is 1010 and the request is withdrawn. A read still drives two data nibbles, then 1111.
- R7: If `frame_n` is sampled low while the target drives LAD, LAD is released in the next clock, no access completes, and a new START is honoured at once.
- R8: A cycle type other than 0000 or 0010 gets no response and no register access.
- R9: An address outside the 8-byte window at 0x0300 (all 16 bits compared) gets no response and no register access.
- R10: While `pwr_down_n` is low, the DMA request line and LAD are tristated and cycles are ignored. After release, the request line is driven high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low bus reset |
| pwr_down_n | input | 1 | Active-low link power-down |
| frame_n | input | 1 | Active-low cycle frame from host |
| lad_in | input | 4 | LAD value seen on the bus |
| lad_out | output | 4 | LAD value driven by the target |
| lad_oe | output | 1 | LAD output enable |
| dma_req_n | output | 1 | Active-low DMA request value (held idle) |
| dma_req_oe | output | 1 | DMA request output enable |
| reg_addr | output | 16 | Register port address |
| reg_wdata | output | 8 | Register port write byte |
| reg_rd | output | 1 | Read request, high until ready |
| reg_wr | output | 1 | Write request, high until ready |
| reg_rdata | input | 8 | Register port read byte |
| reg_ready | input | 1 | Internal target completes the request |

## Verification
The first SYNC nibble is due in the clock right after the host's second turnaround clock. The final SYNC comes at wait number max(ready delay + 1, fixed count), or at wait 330 on a timeout. The data nibbles, the 1111 nibble and the release each follow one clock apart. The driver lines up with the edge that samples the second turnaround nibble and pushes one expected LAD item per clock from that point. The monitor pops one item at every falling edge, so each comparison lands exactly in its due clock. Abort and power-down results are sampled at the first falling edge after the edge that registers the stimulus.

// File: rtl/lpc_tgt_pkg.sv
// Package: shared state encoding and LAD nibble codes for the LPC I/O target.
// Assumes: one nibble per clock on LAD; codes below are fixed by the bus protocol.
package lpc_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTYPE,
        ST_ADDR,
        ST_WDATA,
        ST_TAR1,
        ST_TAR2,
        ST_SYNC,
        ST_RD0,
        ST_RD1,
        ST_TARD
    } lpc_state_e;

    localparam logic [3:0] NIB_START   = 4'b0000;
    localparam logic [3:0] NIB_IORD    = 4'b0000;
    localparam logic [3:0] NIB_IOWR    = 4'b0010;
    localparam logic [3:0] SYNC_READY  = 4'b0000;
    localparam logic [3:0] SYNC_LWAIT  = 4'b0110;
    localparam logic [3:0] SYNC_ERR    = 4'b1010;
    localparam logic [3:0] NIB_TAR     = 4'b1111;

endpackage

// File: rtl/lpc_addr_decode.sv
// Module: compares the upper address bits against the decode window.
// Assumes: window is aligned to its own size (2**WIN_BITS bytes).
module lpc_addr_decode #(
    parameter int          WIN_BITS = 3,
    parameter logic [15:0] WIN_BASE = 16'h0300,
    localparam int         TAG_W    = 16 - WIN_BITS
) (
    input  logic [TAG_W-1:0] addr_tag,
    output logic             hit
);

    // Window match on the tag bits only.
    always_comb hit = (addr_tag == WIN_BASE[15:WIN_BITS]);

endmodule

// File: rtl/lpc_sync_ctrl.sv
// Module: counts SYNC wait nibbles, runs the register-port handshake and
// picks the SYNC code (long wait, ready or error) for each clock.
// Assumes: 'active' is high only while the top is in its SYNC phase; it is
// cleared between cycles, which restarts the count.
module lpc_sync_ctrl
    import lpc_tgt_pkg::*;
#(
    parameter int RD_WAITS  = 3,
    parameter int WR_WAITS  = 2,
    parameter int TMO_SYNCS = 330,
    localparam int CW       = $clog2(TMO_SYNCS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       is_read,
    input  logic       reg_ready,
    input  logic [7:0] reg_rdata,
    output logic       req,
    output logic [3:0] sync_nib,
    output logic       sync_last,
    output logic [7:0] rdata_q
);

    localparam logic [CW-1:0] NEED_RD = CW'(RD_WAITS);
    localparam logic [CW-1:0] NEED_WR = CW'(WR_WAITS);
    localparam logic [CW-1:0] TMO     = CW'(TMO_SYNCS);

    logic [CW-1:0] wcnt;
    logic          acc_done;
    logic          ready_now;
    logic          tmo_now;
    logic [CW-1:0] need;

    // Request is held until ready or until the timeout nibble.
    always_comb begin
        need      = is_read ? NEED_RD : NEED_WR;
        req       = active && !acc_done && (wcnt < TMO);
        ready_now = active && acc_done && (wcnt >= need);
        tmo_now   = active && !acc_done && (wcnt == TMO);
        sync_last = ready_now || tmo_now;
        if (ready_now)    sync_nib = SYNC_READY;
        else if (tmo_now) sync_nib = SYNC_ERR;
        else              sync_nib = SYNC_LWAIT;
    end

    // Wait counter, completion flag and captured read byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            wcnt     <= '0;
            acc_done <= 1'b0;
            rdata_q  <= (rst_n && !active && acc_done) ? rdata_q : 8'hFF;
        end else begin
            wcnt <= wcnt + 1'b1;
            if (req && reg_ready) begin
                acc_done <= 1'b1;
                rdata_q  <= reg_rdata;
            end
        end
    end

endmodule

// File: rtl/lpc_dreq_ctrl.sv
// Module: drives the idle-high DMA request line; tristates it in power-down.
// Assumes: no DMA channel is served, so the line never asserts.
module lpc_dreq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down_n,
    output logic dma_req_n,
    output logic dma_req_oe
);

    assign dma_req_n = 1'b1;

    // Enable follows power-down; reset alone keeps the line driven high.
    always_ff @(posedge clk) begin
        if (!pwr_down_n)  dma_req_oe <= 1'b0;
        else if (!rst_n)  dma_req_oe <= 1'b1;
        else              dma_req_oe <= 1'b1;
    end

endmodule

// File: rtl/lpc_io_target.sv
// Module: LPC I/O read/write target. Decodes START, type, 16-bit address and
// write data, runs SYNC waits through lpc_sync_ctrl, returns read data and
// hands the bus back after a one-clock 1111 turnaround.
// Assumes: 8-bit transfers only; frame_n low always restarts decoding.
module lpc_io_target
    import lpc_tgt_pkg::*;
#(
    parameter int          WIN_BITS  = 3,
    parameter logic [15:0] WIN_BASE  = 16'h0300,
    parameter int          RD_WAITS  = 3,
    parameter int          WR_WAITS  = 2,
    parameter int          TMO_SYNCS = 330
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwr_down_n,
    input  logic        frame_n,
    input  logic [3:0]  lad_in,
    output logic [3:0]  lad_out,
    output logic        lad_oe,
    output logic        dma_req_n,
    output logic        dma_req_oe,
    output logic [15:0] reg_addr,
    output logic [7:0]  reg_wdata,
    output logic        reg_rd,
    output logic        reg_wr,
    input  logic [7:0]  reg_rdata,
    input  logic        reg_ready
);

    lpc_state_e  state;
    logic [1:0]  nib_cnt;
    logic        is_rd;
    logic [15:0] addr_q;
    logic [7:0]  wdata_q;
    logic [15:0] addr_next;
    logic        hit;
    logic        run;
    logic        sync_act;
    logic        req;
    logic [3:0]  sync_nib;
    logic        sync_last;
    logic [7:0]  rdata_q;

    // Block is live only outside reset and power-down.
    always_comb begin
        run       = rst_n && pwr_down_n;
        addr_next = {addr_q[11:0], lad_in};
        sync_act  = run && frame_n && (state == ST_SYNC);
    end

    lpc_addr_decode #(.WIN_BITS(WIN_BITS), .WIN_BASE(WIN_BASE)) u_dec (
        .addr_tag (addr_next[15:WIN_BITS]),
        .hit      (hit)
    );

    lpc_sync_ctrl #(.RD_WAITS(RD_WAITS), .WR_WAITS(WR_WAITS),
                    .TMO_SYNCS(TMO_SYNCS)) u_sync (
        .clk       (clk),
        .rst_n     (run),
        .active    (sync_act),
        .is_read   (is_rd),
        .reg_ready (reg_ready),
        .reg_rdata (reg_rdata),
        .req       (req),
        .sync_nib  (sync_nib),
        .sync_last (sync_last),
        .rdata_q   (rdata_q)
    );

    lpc_dreq_ctrl u_dreq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_down_n (pwr_down_n),
        .dma_req_n  (dma_req_n),
        .dma_req_oe (dma_req_oe)
    );

    // Cycle sequencer: frame low restarts, otherwise step through the phases.
    always_ff @(posedge clk) begin
        if (!run) begin
            state   <= ST_IDLE;
            nib_cnt <= '0;
            is_rd   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (!frame_n) begin
            state <= (lad_in == NIB_START) ? ST_CTYPE : ST_IDLE;
        end else begin
            case (state)
                ST_CTYPE: begin
                    nib_cnt <= '0;
                    if (lad_in == NIB_IORD) begin
                        is_rd <= 1'b1;
                        state <= ST_ADDR;
                    end else if (lad_in == NIB_IOWR) begin
                        is_rd <= 1'b0;
                        state <= ST_ADDR;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_ADDR: begin
                    addr_q  <= addr_next;
                    nib_cnt <= nib_cnt + 1'b1;
                    if (nib_cnt == 2'd3) begin
                        nib_cnt <= '0;
                        if (!hit)       state <= ST_IDLE;
                        else if (is_rd) state <= ST_TAR1;
                        else            state <= ST_WDATA;
                    end
                end
                ST_WDATA: begin
                    if (nib_cnt == 2'd0) begin
                        wdata_q[3:0] <= lad_in;
                        nib_cnt      <= 2'd1;
                    end else begin
                        wdata_q[7:4] <= lad_in;
                        state        <= ST_TAR1;
                    end
                end
                ST_TAR1: state <= ST_TAR2;
                ST_TAR2: state <= ST_SYNC;
                ST_SYNC: if (sync_last) state <= is_rd ? ST_RD0 : ST_TARD;
                ST_RD0:  state <= ST_RD1;
                ST_RD1:  state <= ST_TARD;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus drive and register-port outputs.
    always_comb begin
        lad_oe    = run && (state inside {ST_SYNC, ST_RD0, ST_RD1, ST_TARD});
        reg_addr  = addr_q;
        reg_wdata = wdata_q;
        reg_rd    = req && is_rd;
        reg_wr    = req && !is_rd;
        case (state)
            ST_SYNC: lad_out = sync_nib;
            ST_RD0:  lad_out = rdata_q[3:0];
            ST_RD1:  lad_out = rdata_q[7:4];
            default: lad_out = NIB_TAR;
        endcase
    end

    // R1: reset releases the bus and the register port.
    always @(posedge clk)
        if (!rst_n)
            a_r1_reset_quiet: assert (!lad_oe && !reg_rd && !reg_wr);

    // R7: an abort frame releases LAD in the following clock.
    a_r7_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> !lad_oe);

    // R5: a pending request is only ever seen under a long-wait SYNC.
    a_r5_req_under_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd || reg_wr) |-> (lad_oe && lad_out == SYNC_LWAIT));

    // R4: a read's ready SYNC is preceded by at least three wait nibbles.
    a_r4_read_min_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (lad_oe && state == ST_SYNC && lad_out == SYNC_READY && is_rd) |->
        ($past(lad_out, 1) == SYNC_LWAIT && $past(lad_out, 2) == SYNC_LWAIT
         && $past(lad_out, 3) == SYNC_LWAIT));

    // R6: the error SYNC only follows a driven wait nibble.
    a_r6_err_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (lad_oe && state == ST_SYNC && lad_out == SYNC_ERR) |->
        ($past(lad_oe) && $past(lad_out) == SYNC_LWAIT));

    // R10: power-down keeps LAD released and tristates the request line.
    a_r10_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_down_n |=> (!dma_req_oe && !lad_oe));

endmodule

// File: tb/sim_lpc_io_target.sv
// Bench: scoreboard. Driver tasks play host cycles and push one expected LAD
// item per clock; the monitor pops and compares at every falling edge.
module sim_lpc_io_target;

    localparam int TMO = 330;

    typedef struct packed {
        logic       dc;
        logic       oe;
        logic [3:0] nib;
        logic [7:0] rq;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_down_n = 1'b1;
    logic        frame_n = 1'b1;
    logic [3:0]  lad_in = 4'hF;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic        dma_req_n;
    logic        dma_req_oe;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_rd;
    logic        reg_wr;
    logic [7:0]  reg_rdata;
    logic        reg_ready;

    int checks = 0;
    int errors = 0;
    int rdy_delay = 0;
    int hold_cnt = 0;
    int acc_cnt = 0;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;
    exp_t q[$];

    always #4 clk = ~clk;

    lpc_io_target u0 (
        .clk(clk), .rst_n(rst_n), .pwr_down_n(pwr_down_n), .frame_n(frame_n),
        .lad_in(lad_in), .lad_out(lad_out), .lad_oe(lad_oe),
        .dma_req_n(dma_req_n), .dma_req_oe(dma_req_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_rdata(reg_rdata), .reg_ready(reg_ready)
    );

    // Internal register model: data derived from address, ready after delay.
    assign reg_rdata = reg_addr[7:0] ^ 8'hA5;
    assign reg_ready = (hold_cnt >= rdy_delay);

    always @(posedge clk) begin
        if (reg_rd || reg_wr) hold_cnt <= hold_cnt + 1;
        else                  hold_cnt <= 0;
        if ((reg_rd || reg_wr) && reg_ready) begin
            acc_cnt <= acc_cnt + 1;
            if (reg_wr) begin
                wr_addr <= reg_addr;
                wr_data <= reg_wdata;
            end
        end
    end

    task automatic check(input bit ok, input int rq, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d: actual=%0h expected=%0h", rq, act, expv);
        end
    endtask

    // Monitor: one expected item per clock.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            if (it.oe && !it.dc)
                check(lad_oe && lad_out == it.nib, int'(it.rq),
                      {lad_oe, lad_out}, {1'b1, it.nib});
            else
                check(lad_oe == it.oe, int'(it.rq), lad_oe, it.oe);
        end
    end

    task automatic put(input logic fr, input logic [3:0] n);
        frame_n = fr;
        lad_in  = n;
        @(posedge clk);
        #1;
        frame_n = 1'b1;
        lad_in  = 4'hF;
    endtask

    task automatic push(input logic dc, input logic oe, input logic [3:0] n,
                        input int rq);
        q.push_back({dc, oe, n, 8'(rq)});
    endtask

    task automatic drain();
        while (q.size() != 0) @(posedge clk);
        #1;
    endtask

    task automatic send_addr(input logic [15:0] a);
        put(1, a[15:12]); put(1, a[11:8]); put(1, a[7:4]); put(1, a[3:0]);
    endtask

    // Host I/O read (R2, R4, R5, R6).
    task automatic io_read(input logic [15:0] a, input int d, input int rq);
        int   w;
        bit   err;
        logic [7:0] dv;
        int   acc0;
        acc0 = acc_cnt;
        rdy_delay = d;
        err = (d + 1 > TMO);
        w = err ? TMO : ((d + 1 > 3) ? d + 1 : 3);
        dv = a[7:0] ^ 8'hA5;
        put(0, 4'h0); put(1, 4'h0); send_addr(a);
        put(1, 4'hF); put(1, 4'hF);
        for (int i = 0; i < w; i++) push(0, 1, 4'b0110, rq);
        push(0, 1, err ? 4'b1010 : 4'b0000, rq);
        push(err, 1, dv[3:0], rq);
        push(err, 1, dv[7:4], rq);
        push(0, 1, 4'hF, 2);
        push(0, 0, 4'h0, 2);
        drain();
        check(acc_cnt == acc0 + (err ? 0 : 1), rq, acc_cnt - acc0, err ? 0 : 1);
    endtask

    // Host I/O write (R3, R4, R5).
    task automatic io_write(input logic [15:0] a, input logic [7:0] dv,
                            input int d, input int rq);
        int w;
        int acc0;
        acc0 = acc_cnt;
        rdy_delay = d;
        w = (d + 1 > 2) ? d + 1 : 2;
        put(0, 4'h0); put(1, 4'h2); send_addr(a);
        put(1, dv[3:0]); put(1, dv[7:4]);
        put(1, 4'hF); put(1, 4'hF);
        for (int i = 0; i < w; i++) push(0, 1, 4'b0110, rq);
        push(0, 1, 4'b0000, rq);
        push(0, 1, 4'hF, 3);
        push(0, 0, 4'h0, 3);
        drain();
        // R3: address and byte reached the register port once
        check(acc_cnt == acc0 + 1, 3, acc_cnt - acc0, 1);
        check(wr_addr == a, 3, wr_addr, a);
        check(wr_data == dv, 3, wr_data, dv);
    endtask

    // Cycle that must get no response (R8, R9, R10).
    task automatic io_ignored(input logic [3:0] ty, input logic [15:0] a,
                              input int rq);
        int acc0;
        acc0 = acc_cnt;
        put(0, 4'h0); put(1, ty);
        for (int i = 0; i < 10; i++) push(0, 0, 4'h0, rq);
        send_addr(a);
        put(1, 4'h3); put(1, 4'hC);
        for (int i = 0; i < 4; i++) put(1, 4'hF);
        drain();
        check(acc_cnt == acc0, rq, acc_cnt - acc0, 0);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!lad_oe, 1, lad_oe, 0);
        check(dma_req_oe && dma_req_n, 1, {dma_req_oe, dma_req_n}, 2'b11);
        check(!reg_rd && !reg_wr, 1, {reg_rd, reg_wr}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R2 / R4: reads at both window edges, ready at once
        io_read(16'h0300, 0, 4);
        io_read(16'h0307, 0, 2);
        // R3 / R4: writes
        io_write(16'h0305, 8'h3C, 0, 4);
        io_write(16'h0301, 8'hE7, 0, 3);
        // R5: held-off ready
        io_read(16'h0302, 6, 5);
        io_write(16'h0306, 8'h81, 4, 5);
        // R6: timeout with error SYNC and two data nibbles
        io_read(16'h0304, 1000, 6);
        io_read(16'h0303, 0, 6);
        // R8: unsupported cycle types
        io_ignored(4'h4, 16'h0300, 8);
        io_ignored(4'h8, 16'h0300, 8);
        // R9: outside the window (upper bits compared too)
        io_ignored(4'h0, 16'h0308, 9);
        io_ignored(4'h2, 16'h02FF, 9);
        io_ignored(4'h0, 16'h1300, 9);

        // R7: abort while SYNC is driven
        begin
            int acc0;
            acc0 = acc_cnt;
            rdy_delay = 50;
            put(0, 4'h0); put(1, 4'h0); send_addr(16'h0300);
            put(1, 4'hF); put(1, 4'hF);
            repeat (3) @(posedge clk);
            #1;
            @(negedge clk);
            check(lad_oe, 7, lad_oe, 1);
            @(posedge clk); #1;
            put(0, 4'hF);
            @(negedge clk);
            check(!lad_oe, 7, lad_oe, 0);
            @(posedge clk); #1;
            check(acc_cnt == acc0, 7, acc_cnt - acc0, 0);
            io_read(16'h0306, 0, 7);
        end

        // R10: power-down
        pwr_down_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(!dma_req_oe, 10, dma_req_oe, 0);
        @(posedge clk); #1;
        io_ignored(4'h0, 16'h0300, 10);
        pwr_down_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(dma_req_oe && dma_req_n, 10, {dma_req_oe, dma_req_n}, 2'b11);
        @(posedge clk); #1;
        io_read(16'h0305, 0, 10);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule